// File: doc/BRIEF.md
# Physical Memory Access Permission Checker

This block decides whether a physical memory access may go ahead. Each access gives a physical address, a privilege level and a kind (read, write or execute). The block compares it against a parameterised set of protection entries. Every entry holds an 8-bit configuration value and an address register. The configuration value carries the permission bits, a region mode and a lock bit. The address register holds physical address bits `PA_W-1:2`. The lowest-numbered entry whose region contains the address decides the result. The block returns allow or deny, a hit flag and the index of the deciding entry, one clock after the access is presented.

Software-visible state is written through a single write port that targets either an entry's configuration or its address register. A combinational read port returns the values as software would see them. A region can be a range bounded by the previous entry's address, a single aligned word, or an aligned power-of-two block whose size is encoded by the trailing ones of the address register. The `G` parameter sets the smallest region at 2^(G+2) bytes. It also changes how address registers read back and how they take part in matching. A locked entry ignores writes until reset and also binds machine mode.

Top module: `pmp_checker`

## Requirements
- R1: `req_type` is 0 for read, 1 for write and 2 for execute. A matched entry grants these through configuration bit 0 (read), bit 1 (write) and bit 2 (execute). Code 3 is reserved and is always denied.
- R2: A request sampled at a clock edge has its result on `rsp_*` after that same edge, so `rsp_valid` is `req_valid` delayed by one cycle. While `rsp_valid` is low, `rsp_allow`, `rsp_hit` and `rsp_idx` are zero. A register write takes effect for requests sampled at later edges.
- R3: Mode field bits 4:3 = 1 selects a range region: word addresses `addr[PA_W-1:2]` in [previous entry's address register, this entry's address register). Entry 0 uses 0 as its lower bound, and the upper bound itself is outside the region.
- R4: Mode 2 matches only the one 4-byte word whose word address equals the address register.
- R5: Mode 3 matches an aligned block of 2^(k+3) bytes, where k is the number of trailing ones in the address register. The block base is the register with those ones and the zero above them cleared.
- R6: When several entries match, the lowest-numbered one decides. `rsp_hit` is 1 and `rsp_idx` gives its index.
- R7: When no entry matches, `rsp_hit` and `rsp_idx` are 0. A machine-mode access (`req_priv` = 3) is allowed. Any other privilege is denied if any entry has a non-zero mode, and allowed if every entry is off.
- R8: A machine-mode access that matches an unlocked entry is allowed whatever its permission bits. If the matched entry's lock bit (bit 7) is set, the permission bits apply to machine mode too.
- R9: Writes to the configuration or address register of a locked entry are ignored. The lock cannot be cleared except by reset.
- R10: A locked entry in range mode also blocks writes to the preceding entry's address register. A locked entry in any other mode does not.
- R11: Configuration bits 6:5 are stored and read as zero. With `G` >= 1, a written mode of 2 is stored as 0 (off).
- R12: With `G` >= 1, address bits `G-1:0` read as zero for entries that are off or in range mode. With `G` >= 2, address bits `G-2:0` read as ones for power-of-two entries. Matching uses these read-back values.
- R13: Reset clears every configuration value and address register and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_cfg | input | 1 | 1 writes configuration (low 8 bits of data), 0 writes the address register |
| wr_idx | input | IDX_W | Entry targeted by the write |
| wr_data | input | PA_W-2 | Write data |
| rd_idx | input | IDX_W | Entry selected for read-back |
| rd_is_cfg | input | 1 | 1 reads configuration, 0 reads the address register |
| rd_data | output | PA_W-2 | Combinational read-back value |
| req_valid | input | 1 | Access request present |
| req_addr | input | PA_W | Physical byte address |
| req_priv | input | 2 | Privilege: 3 machine, lower values less privileged |
| req_type | input | 2 | Access kind, see R1 |
| rsp_valid | output | 1 | Result present |
| rsp_allow | output | 1 | Access permitted |
| rsp_hit | output | 1 | Some entry matched |
| rsp_idx | output | IDX_W | Index of the deciding entry |

## Verification
The bench aims at region edges. These are the word at a range's upper bound, the first and last word of a power-of-two block, and the word just past each end. An off-by-one comparator would grant access one word too far or drop the last word. Overlapping entries catch a design that picks the highest index. A lock on a range entry that still lets its neighbour's address change would let software move a locked boundary. A second instance with a coarse granule shows whether the masked low bits are used in matching and not only in read-back; a design that got this wrong would still match on the raw stored bits.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] zero;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ecfg_t;

    localparam logic [1:0] PRIV_M = 2'd3;
    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

endpackage

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
    import pmp_chk_pkg::*;
#(
    parameter int N      = 8,
    parameter int AREG_W = 32,
    parameter int G      = 0,
    parameter int IDX_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_is_cfg,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [AREG_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic                        rd_is_cfg,
    output logic [AREG_W-1:0]           rd_data,
    output logic [N-1:0][7:0]           cfg_o,
    output logic [N-1:0][AREG_W-1:0]    shaped_o,
    output logic [N-1:0][AREG_W-1:0]    torv_o
);

    localparam int OSH = (G >= 2) ? G - 1 : 0;
    localparam logic [AREG_W-1:0] ZMASK = (G >= 1) ? AREG_W'((64'd1 << G) - 64'd1) : '0;
    localparam logic [AREG_W-1:0] OMASK = (G >= 2) ? AREG_W'((64'd1 << OSH) - 64'd1) : '0;

    typedef struct packed {
        logic [N-1:0][7:0]        cfg;
        logic [N-1:0][AREG_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] addr_blk;

    function automatic logic [7:0] legal_cfg(input logic [7:0] raw);
        ecfg_t c;
        c      = ecfg_t'(raw);
        c.zero = 2'b00;
        if (G >= 1 && c.mode == AM_NA4) c.mode = AM_OFF;
        return c;
    endfunction

    function automatic logic [AREG_W-1:0] shape(input logic [AREG_W-1:0] v, input logic [7:0] c);
        if (c[4:3] == AM_NAPOT) return v | OMASK;
        return v & ~ZMASK;
    endfunction

    // address writes are blocked by the entry's own lock or a locked range entry above it
    for (genvar g = 0; g < N; g++) begin : g_blk
        if (g < N - 1) begin : g_nxt
            assign addr_blk[g] = st_q.cfg[g][7] |
                                 (st_q.cfg[g+1][7] & (st_q.cfg[g+1][4:3] == AM_TOR));
        end else begin : g_last
            assign addr_blk[g] = st_q.cfg[g][7];
        end
        assign cfg_o[g]    = st_q.cfg[g];
        assign shaped_o[g] = shape(st_q.addr[g], st_q.cfg[g]);
        assign torv_o[g]   = st_q.addr[g] & ~ZMASK;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (wr_is_cfg) begin
                        if (!st_q.cfg[i][7]) st_d.cfg[i] = legal_cfg(wr_data[7:0]);
                    end else if (!addr_blk[i]) begin
                        st_d.addr[i] = wr_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                if (rd_is_cfg) rd_data = {{(AREG_W-8){1'b0}}, st_q.cfg[i]};
                else           rd_data = shaped_o[i];
            end
        end
    end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
    import pmp_chk_pkg::*;
#(
    parameter int AREG_W = 32
) (
    input  logic [AREG_W-1:0] addr_w,
    input  logic [7:0]        cfg,
    input  logic [AREG_W-1:0] shaped,
    input  logic [AREG_W-1:0] lo,
    output logic              hit
);

    logic [AREG_W-1:0] ign;

    always_comb begin
        // trailing ones plus the zero above them form the don't-care field
        ign = shaped ^ (shaped + AREG_W'(1));
        case (amode_e'(cfg[4:3]))
            AM_TOR:   hit = (addr_w >= lo) && (addr_w < shaped);
            AM_NA4:   hit = (addr_w == shaped);
            AM_NAPOT: hit = ((addr_w ^ shaped) & ~ign) == '0;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PA_W      = 34,
    parameter int G         = 0,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int AREG_W   = PA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_is_cfg,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [AREG_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_is_cfg,
    output logic [AREG_W-1:0] rd_data,
    input  logic              req_valid,
    input  logic [PA_W-1:0]   req_addr,
    input  logic [1:0]        req_priv,
    input  logic [1:0]        req_type,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx
);

    typedef struct packed {
        logic             valid;
        logic             allow;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } rsp_t;

    logic [N_ENTRIES-1:0][7:0]        cfg_all;
    logic [N_ENTRIES-1:0][AREG_W-1:0] shaped;
    logic [N_ENTRIES-1:0][AREG_W-1:0] torv;
    logic [N_ENTRIES-1:0]             hits;
    logic [N_ENTRIES-1:0]             ent_on;
    logic                             any_hit;
    logic [IDX_W-1:0]                 sel_idx;
    rsp_t                             rsp_d, rsp_q;

    pmp_entry_regs #(
        .N(N_ENTRIES), .AREG_W(AREG_W), .G(G), .IDX_W(IDX_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_is_cfg(wr_is_cfg),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_is_cfg(rd_is_cfg),
        .rd_data  (rd_data),
        .cfg_o    (cfg_all),
        .shaped_o (shaped),
        .torv_o   (torv)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic [AREG_W-1:0] lo;
        if (g == 0) begin : g_first
            assign lo = '0;
        end else begin : g_rest
            assign lo = torv[g-1];
        end
        assign ent_on[g] = (cfg_all[g][4:3] != AM_OFF);
        pmp_entry_match #(.AREG_W(AREG_W)) match_i (
            .addr_w(req_addr[PA_W-1:2]),
            .cfg   (cfg_all[g]),
            .shaped(shaped[g]),
            .lo    (lo),
            .hit   (hits[g])
        );
    end

    pmp_prio_sel #(.N(N_ENTRIES), .IDX_W(IDX_W)) prio_i (
        .hits(hits),
        .any (any_hit),
        .idx (sel_idx)
    );

    always_comb begin
        ecfg_t sc;
        logic  perm;
        sc = ecfg_t'(cfg_all[sel_idx]);
        if (any_hit) begin
            if (req_priv == PRIV_M && !sc.lock) begin
                perm = 1'b1;
            end else begin
                case (req_type)
                    ACC_RD:  perm = sc.r;
                    ACC_WR:  perm = sc.w;
                    ACC_EX:  perm = sc.x;
                    default: perm = 1'b0;
                endcase
            end
        end else begin
            perm = (req_priv == PRIV_M) || !(|ent_on);
        end
        if (req_type == 2'd3) perm = 1'b0;

        rsp_d.valid = req_valid;
        rsp_d.allow = req_valid & perm;
        rsp_d.hit   = req_valid & any_hit;
        rsp_d.idx   = req_valid ? sel_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;

endmodule

// File: rtl/pmp_checker_chk.sv
module pmp_checker_chk #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [1:0]                req_priv,
    input logic [1:0]                req_type,
    input logic                      rsp_valid,
    input logic                      rsp_allow,
    input logic                      rsp_hit,
    input logic [IDX_W-1:0]          rsp_idx,
    input logic [N_ENTRIES-1:0][7:0] cfg_all
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_hit && rsp_idx == '0));

    // R1
    rsvd_type_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd3) |=> !rsp_allow);

    // R7
    m_nomatch_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == 2'd3 && req_type != 2'd3) |=> (rsp_allow || rsp_hit));

    // R7
    miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_idx == '0);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_lk
        // R9
        lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_all[g][7] |=> cfg_all[g][7]);
        // R9
        lock_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_all[g][7] |=> $stable(cfg_all[g]));
        // R11
        cfg_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_all[g][6:5] == 2'b00);
    end

endmodule

bind pmp_checker pmp_checker_chk #(
    .N_ENTRIES(N_ENTRIES),
    .IDX_W    (IDX_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_priv (req_priv),
    .req_type (req_type),
    .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow),
    .rsp_hit  (rsp_hit),
    .rsp_idx  (rsp_idx),
    .cfg_all  (cfg_all)
);

// File: tb/pmp_checker_tb_top.sv
`timescale 1ns/1ps
module pmp_checker_tb_top;

    int checks = 0;
    int errors = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // main instance: 8 entries, G = 0
    logic        wr_en = 0, wr_is_cfg = 0, rd_is_cfg = 0, req_valid = 0;
    logic [2:0]  wr_idx = 0, rd_idx = 0, rsp_idx;
    logic [31:0] wr_data = 0, rd_data;
    logic [33:0] req_addr = 0;
    logic [1:0]  req_priv = 0, req_type = 0;
    logic        rsp_valid, rsp_allow, rsp_hit;

    pmp_checker #(.N_ENTRIES(8), .PA_W(34), .G(0)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_is_cfg(wr_is_cfg), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_is_cfg(rd_is_cfg), .rd_data(rd_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_priv(req_priv), .req_type(req_type),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    // coarse-granule instance: 4 entries, G = 2
    logic        g_wr_en = 0, g_wr_is_cfg = 0, g_rd_is_cfg = 0, g_req_valid = 0;
    logic [1:0]  g_wr_idx = 0, g_rd_idx = 0, g_rsp_idx;
    logic [31:0] g_wr_data = 0, g_rd_data;
    logic [33:0] g_req_addr = 0;
    logic [1:0]  g_req_priv = 0, g_req_type = 0;
    logic        g_rsp_valid, g_rsp_allow, g_rsp_hit;

    pmp_checker #(.N_ENTRIES(4), .PA_W(34), .G(2)) dut_g (
        .clk(clk), .rst_n(rst_n),
        .wr_en(g_wr_en), .wr_is_cfg(g_wr_is_cfg), .wr_idx(g_wr_idx), .wr_data(g_wr_data),
        .rd_idx(g_rd_idx), .rd_is_cfg(g_rd_is_cfg), .rd_data(g_rd_data),
        .req_valid(g_req_valid), .req_addr(g_req_addr), .req_priv(g_req_priv), .req_type(g_req_type),
        .rsp_valid(g_rsp_valid), .rsp_allow(g_rsp_allow), .rsp_hit(g_rsp_hit), .rsp_idx(g_rsp_idx)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected results as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", {59'd0, rsp_allow, rsp_hit, rsp_idx}, 64'd0);
            end else begin
                cur = sb_q.pop_front();
                check({rsp_allow, rsp_hit, rsp_idx} == cur.exp, cur.tag,
                      {59'd0, rsp_allow, rsp_hit, rsp_idx}, {59'd0, cur.exp});
            end
        end
    end

    task automatic wr(input bit is_cfg, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_is_cfg = is_cfg; wr_idx = 3'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input bit is_cfg, input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_is_cfg = is_cfg; rd_idx = 3'(idx);
        #1;
        check(rd_data == exp, tag, {32'd0, rd_data}, {32'd0, exp});
    endtask

    // driver: pushes the expected item, then presents the access for one cycle
    task automatic acc(input logic [31:0] w, input logic [1:0] priv, input logic [1:0] kind,
                       input bit allow, input bit hit, input int idx, input string tag);
        exp_t e;
        e.exp = {allow, hit, 3'(idx)};
        e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        req_addr = {w, 2'b00}; req_priv = priv; req_type = kind; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic g_wr(input bit is_cfg, input int idx, input logic [31:0] d);
        @(negedge clk);
        g_wr_en = 1; g_wr_is_cfg = is_cfg; g_wr_idx = 2'(idx); g_wr_data = d;
        @(negedge clk);
        g_wr_en = 0;
    endtask

    task automatic g_rd_chk(input bit is_cfg, input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        g_rd_is_cfg = is_cfg; g_rd_idx = 2'(idx);
        #1;
        check(g_rd_data == exp, tag, {32'd0, g_rd_data}, {32'd0, exp});
    endtask

    task automatic g_acc(input logic [31:0] w, input bit allow, input bit hit, input int idx, input string tag);
        @(negedge clk);
        g_req_addr = {w, 2'b00}; g_req_priv = 2'd0; g_req_type = 2'd0; g_req_valid = 1;
        @(negedge clk);
        g_req_valid = 0;
        check({g_rsp_valid, g_rsp_allow, g_rsp_hit, g_rsp_idx} == {1'b1, allow, hit, 2'(idx)}, tag,
              {59'd0, g_rsp_valid, g_rsp_allow, g_rsp_hit, g_rsp_idx},
              {59'd0, 1'b1, allow, hit, 2'(idx)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        check(rsp_valid == 0, "R13 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        rd_chk(1, 0, 32'h0, "R13 cfg0 reset");
        rd_chk(0, 3, 32'h0, "R13 addr3 reset");
        // R7 all entries off: user access allowed
        acc(32'h40, 2'd0, 2'd1, 1, 0, 0, "R7 all off user allowed");

        // entry0 range [0,0x100) R; entry1 word 0x200 W|X; entry2 block 0x300..0x307 RWX;
        // entry3 range [0x303,0x400) X
        wr(0, 0, 32'h100); wr(1, 0, 32'h09);
        wr(0, 1, 32'h200); wr(1, 1, 32'h16);
        wr(0, 2, 32'h303); wr(1, 2, 32'h1F);
        wr(0, 3, 32'h400); wr(1, 3, 32'h0C);

        acc(32'h0,   2'd0, 2'd0, 1, 1, 0, "R3 lower bound zero");
        acc(32'hFF,  2'd0, 2'd1, 0, 1, 0, "R1 write denied on read-only");
        acc(32'hFF,  2'd0, 2'd0, 1, 1, 0, "R3 last word in range");
        acc(32'h100, 2'd0, 2'd0, 0, 0, 0, "R3 upper bound excluded, R7 deny");
        acc(32'h200, 2'd1, 2'd1, 1, 1, 1, "R4 word write allowed");
        acc(32'h200, 2'd1, 2'd0, 0, 1, 1, "R1 word read denied");
        acc(32'h201, 2'd0, 2'd1, 0, 0, 0, "R4 next word misses");
        acc(32'h300, 2'd0, 2'd0, 1, 1, 2, "R5 block first word");
        acc(32'h307, 2'd0, 2'd0, 1, 1, 2, "R5 block last word");
        acc(32'h2FF, 2'd0, 2'd0, 0, 0, 0, "R5 below block misses");
        acc(32'h308, 2'd0, 2'd0, 0, 1, 3, "R5 past block, range entry");
        acc(32'h305, 2'd0, 2'd1, 1, 1, 2, "R6 overlap lowest index");
        acc(32'h310, 2'd0, 2'd2, 1, 1, 3, "R1 execute allowed");
        acc(32'h0,   2'd3, 2'd1, 1, 1, 0, "R8 machine ignores unlocked bits");
        acc(32'h100, 2'd3, 2'd0, 1, 0, 0, "R7 machine miss allowed");
        acc(32'h100, 2'd3, 2'd3, 0, 0, 0, "R1 reserved type denied");

        // R9 lock entry0
        wr(1, 0, 32'h89);
        acc(32'h0, 2'd3, 2'd1, 0, 1, 0, "R8 locked binds machine");
        wr(1, 0, 32'h00);
        rd_chk(1, 0, 32'h89, "R9 locked cfg write ignored");
        wr(0, 0, 32'h50);
        rd_chk(0, 0, 32'h100, "R9 locked addr write ignored");
        acc(32'h0, 2'd3, 2'd0, 1, 1, 0, "R9 entry still active");

        // R10 locked range entry 3 guards addr2
        wr(1, 3, 32'h8C);
        wr(0, 2, 32'h0);
        rd_chk(0, 2, 32'h303, "R10 addr below locked range frozen");
        wr(1, 5, 32'h98);
        wr(0, 4, 32'h7);
        rd_chk(0, 4, 32'h7, "R10 locked block entry does not guard");

        // R11 reserved cfg bits
        wr(1, 6, 32'h61);
        rd_chk(1, 6, 32'h01, "R11 cfg bits 6:5 zero");

        // coarse granule instance
        g_wr(1, 0, 32'h10);
        g_rd_chk(1, 0, 32'h00, "R11 word mode unselectable");
        g_wr(0, 0, 32'h107); g_wr(1, 0, 32'h09);
        g_rd_chk(0, 0, 32'h104, "R12 range low bits zero");
        g_wr(0, 1, 32'h200); g_wr(1, 1, 32'h19);
        g_rd_chk(0, 1, 32'h201, "R12 block low bit one");
        g_acc(32'h203, 1, 1, 1, "R12 block spans 4 words");
        g_acc(32'h204, 0, 0, 0, "R12 block ends");
        g_acc(32'h103, 1, 1, 0, "R12 range below masked bound");
        g_acc(32'h105, 0, 0, 0, "R12 masked bound used in match");

        // R13 reset clears locks
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2 all responses seen", 64'(sb_q.size()), 64'd0);
        do_reset();
        rd_chk(1, 0, 32'h0, "R13 cfg0 cleared");
        rd_chk(0, 2, 32'h0, "R13 addr2 cleared");
        wr(1, 0, 32'h09);
        rd_chk(1, 0, 32'h09, "R9 lock released by reset");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule